// File: doc/BRIEF.md
# UART Host Register and Interrupt Flag Controller

This block is the host-side register front end of a UART whose receive and transmit paths each have a 16-entry FIFO. It holds the control word, the baud divisor word and the six event flags. It decodes writes from a simple word-addressed bus and returns read data without a wait state. The serial shifters, the baud generator and the FIFOs sit outside the block. Only the FIFO fill counts, the head byte of the receive FIFO, receiver error pulses and a one-cycle bit-time tick reach this block.

Software changes flags through a write-only command word. Each flag has its own set bit and its own clear bit, so one write never disturbs a flag it does not name. The same command word also pops or flushes the FIFOs. The transmit-ready flag is raised when the transmit fill falls to a programmed level. The receive-ready flag is raised once a programmed number of bit times has passed since the receive FIFO stopped being empty. One level interrupt output is the OR of the flags that are enabled.

Top module: `uart_hostregs`

## Requirements
- R1: While rst_n is low, all six flags, the control word, the baud word, irq and the pulse outputs rx_pop, rx_flush, tx_flush and tx_push are 0.
- R2: The control word (byte offset 4) stores bits 25:0 and reads them back, with bits 31:26 reading 0. frame_cfg shows control bits 13:6. The baud word (offset 8) stores bits 15:0, reads them back and drives baud_cfg.
- R3: The status word (offset 16) has flags in bits 5:0: bit 0 receive-ready, bit 1 transmit-ready, bit 2 overrun, bit 3 break, bit 4 framing error, bit 5 parity error. It has rx_count in bits 10:6 and tx_count in bits 15:11. Bits 31:16 read 0. The command word (offset 12) reads 0.
- R4: In a write to the command word (offset 12), bits 0 to 4 clear receive-ready, overrun, break, framing and parity. Bits 5 to 9 set the same flags in the same order. Bit 13 clears transmit-ready and bit 14 sets it. Each flag changes on the clock edge that takes the write. Flags that are not named keep their value.
- R5: If a flag's set bit and clear bit are in the same write, the flag ends up at 1. If a hardware event for a flag arrives in the same cycle as its clear bit, the flag also ends up at 1.
- R6: A one-cycle pulse on ev_overrun, ev_break, ev_frame or ev_parity sets the matching flag at the next edge. The flag then stays at 1 until software clears it.
- R7: Transmit-ready is set at the edge after tx_count <= control bits 25:22 turns from false to true. While that condition stays true, the flag is not set again after software clears it.
- R8: A delay counter counts bit_tick pulses while rx_count is non-zero and returns to 0 while rx_count is zero. Receive-ready is set at the edge after the counter first reaches the delay in control bits 21:14. A delay of 0 raises the flag at the edge after rx_count becomes non-zero.
- R9: irq is 1 exactly when some flag is 1 and its enable is 1. The enables are control bits 0 to 5, in the order receive-ready, overrun, break, framing, parity, transmit-ready.
- R10: Command bits 10, 11 and 12 produce a one-cycle pulse on rx_pop, rx_flush and tx_flush. The pulse is high in the cycle after the write.
- R11: A write to offset 0 produces a one-cycle tx_push in the cycle after the write, with tx_byte equal to write data bits 7:0. A read of offset 0 returns rx_head in bits 7:0. A read of offset 20 returns the ID_WORD parameter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_addr | input | 5 | Byte address of the word (bits 4:2 used) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| rx_head | input | 8 | Character at the head of the receive FIFO |
| rx_count | input | 5 | Receive FIFO fill count |
| tx_count | input | 5 | Transmit FIFO fill count |
| bit_tick | input | 1 | One-cycle pulse per serial bit time |
| ev_overrun | input | 1 | Receiver overrun pulse |
| ev_break | input | 1 | Break detected pulse |
| ev_frame | input | 1 | Framing error pulse |
| ev_parity | input | 1 | Parity error pulse |
| irq | output | 1 | Interrupt request, level |
| rx_pop | output | 1 | Pop one character from the receive FIFO |
| rx_flush | output | 1 | Empty the receive FIFO |
| tx_flush | output | 1 | Empty the transmit FIFO |
| tx_push | output | 1 | Push tx_byte into the transmit FIFO |
| tx_byte | output | 8 | Character to push |
| frame_cfg | output | 8 | Frame settings to the serial engine (control bits 13:6) |
| baud_cfg | output | 16 | Baud divisor word |

## Verification
Every register result is due one edge after its cause. That holds for a command bit, an error pulse, a control write and a pop, flush or push request, so the bench drives on the falling edge and reads at the next falling edge. The status and interrupt outputs are combinational on the flags, so they are sampled one full cycle after the write, never in the same cycle. The receive-ready path has one more stage. The counter reaches the delay on the tick edge and the flag rises on the edge after that, so the bench checks for 0 just after the last tick and for 1 one cycle later. The transmit-ready path rises one edge after the count crosses the threshold.

// File: rtl/uart_hreg_pkg.sv
// Package: shared constants for the UART host register block.
// Assumes word-addressed registers at byte offsets 0,4,8,12,16,20.
package uart_hreg_pkg;
    localparam int NFLAG    = 6;
    // flag positions in the status word
    localparam int F_RRDY   = 0;
    localparam int F_TRDY   = 1;
    localparam int F_OE     = 2;
    localparam int F_BRK    = 3;
    localparam int F_FE     = 4;
    localparam int F_PE     = 5;
    // word index decoded from bus_addr[4:2]
    localparam logic [2:0] W_DATA = 3'd0;
    localparam logic [2:0] W_CTRL = 3'd1;
    localparam logic [2:0] W_BAUD = 3'd2;
    localparam logic [2:0] W_CMD  = 3'd3;
    localparam logic [2:0] W_STAT = 3'd4;
    localparam logic [2:0] W_ID   = 3'd5;
    // command bits beyond the per-flag set/clear group
    localparam int C_POP    = 10;
    localparam int C_RXCLR  = 11;
    localparam int C_TXCLR  = 12;
    localparam int C_TRDYC  = 13;
    localparam int C_TRDYS  = 14;
    localparam int C_SETOFS = 5;   // set bits follow the clear bits
    // control word fields
    localparam int CTRL_W   = 26;
    localparam int K_FRM_LO = 6;
    localparam int K_DLY_LO = 14;
    localparam int K_THR_LO = 22;
    localparam int BAUD_W   = 16;

    // Order of the five receive flags within the set/clear groups.
    function automatic int rx_flag_at(input int slot);
        case (slot)
            0:       return F_RRDY;
            1:       return F_OE;
            2:       return F_BRK;
            3:       return F_FE;
            default: return F_PE;
        endcase
    endfunction
endpackage

// File: rtl/uart_flag_bank.sv
// Module: uart_flag_bank
// A row of sticky flags. Each flag is set by software or hardware and
// cleared by software. A set request in the same cycle beats a clear.
// Assumes every request is a single-cycle strobe.
module uart_flag_bank #(
    parameter int NF = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [NF-1:0] sw_set,
    input  logic [NF-1:0] sw_clr,
    input  logic [NF-1:0] hw_set,
    output logic [NF-1:0] flags
);
    for (genvar i = 0; i < NF; i++) begin : g_flag
        // one flag: set dominates clear, otherwise hold
        always_ff @(posedge clk) begin
            if (!rst_n)                      flags[i] <= 1'b0;
            else if (sw_set[i] || hw_set[i]) flags[i] <= 1'b1;
            else if (sw_clr[i])              flags[i] <= 1'b0;
        end
    end
endmodule

// File: rtl/uart_rdy_gen.sv
// Module: uart_rdy_gen
// Makes the one-cycle hardware set requests for receive-ready and
// transmit-ready. Receive-ready waits a programmed number of bit ticks
// after the receive FIFO becomes non-empty. Transmit-ready follows the
// transmit fill reaching a threshold. Both requests fire on the rising
// edge of their condition.
// Assumes bit_tick is a single-cycle pulse.
module uart_rdy_gen #(
    parameter int CNT_W = 5,
    parameter int DLY_W = 8,
    parameter int THR_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] rx_count,
    input  logic [CNT_W-1:0] tx_count,
    input  logic             bit_tick,
    input  logic [DLY_W-1:0] rx_delay,
    input  logic [THR_W-1:0] tx_thr,
    output logic             rx_rise,
    output logic             tx_rise
);
    localparam int CMP_W = (CNT_W > THR_W) ? CNT_W : THR_W;
    localparam logic [DLY_W-1:0] DLY_MAX = {DLY_W{1'b1}};

    logic [DLY_W-1:0] dly_cnt;
    logic             rx_cond, tx_cond, rx_cond_q, tx_cond_q;
    logic [CMP_W-1:0] tx_fill_x, tx_thr_x;

    // bit-time counter: cleared while empty, saturating count otherwise
    always_ff @(posedge clk) begin
        if (!rst_n || rx_count == '0)           dly_cnt <= '0;
        else if (bit_tick && dly_cnt != DLY_MAX) dly_cnt <= dly_cnt + 1'b1;
    end

    // ready conditions on common-width operands
    always_comb begin
        tx_fill_x = CMP_W'(tx_count);
        tx_thr_x  = CMP_W'(tx_thr);
        rx_cond   = (rx_count != '0) && (dly_cnt >= rx_delay);
        tx_cond   = (tx_fill_x <= tx_thr_x);
    end

    // previous-cycle copies for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_cond_q <= 1'b0;
            tx_cond_q <= 1'b0;
        end else begin
            rx_cond_q <= rx_cond;
            tx_cond_q <= tx_cond;
        end
    end

    assign rx_rise = rx_cond & ~rx_cond_q;
    assign tx_rise = tx_cond & ~tx_cond_q;
endmodule

// File: rtl/uart_hostregs.sv
// Module: uart_hostregs (top)
// Host register front end of a FIFO-buffered UART. It decodes word
// writes, holds the control and baud words, drives the flags from the
// command word and the receiver events, and combines the enabled flags
// into irq. Reads are combinational on bus_addr.
// Assumes one write per bus_wr cycle and FIFO counts of at most 16.
module uart_hostregs
    import uart_hreg_pkg::*;
#(
    parameter int          FIFO_DEPTH = 16,
    parameter int          DLY_W      = 8,
    parameter int          THR_W      = 4,
    parameter logic [31:0] ID_WORD    = 32'h5A17_0001,
    localparam int         CNT_W      = $clog2(FIFO_DEPTH) + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_wr,
    input  logic [4:0]       bus_addr,
    input  logic [31:0]      bus_wdata,
    output logic [31:0]      bus_rdata,
    input  logic [7:0]       rx_head,
    input  logic [CNT_W-1:0] rx_count,
    input  logic [CNT_W-1:0] tx_count,
    input  logic             bit_tick,
    input  logic             ev_overrun,
    input  logic             ev_break,
    input  logic             ev_frame,
    input  logic             ev_parity,
    output logic             irq,
    output logic             rx_pop,
    output logic             rx_flush,
    output logic             tx_flush,
    output logic             tx_push,
    output logic [7:0]       tx_byte,
    output logic [7:0]       frame_cfg,
    output logic [15:0]      baud_cfg
);
    localparam int RXC_LO = NFLAG;
    localparam int TXC_LO = NFLAG + CNT_W;
    localparam int STAT_W = NFLAG + 2 * CNT_W;

    logic [2:0]        widx;
    logic              we_data, we_ctrl, we_baud, we_cmd;
    logic [CTRL_W-1:0] ctrl_q;
    logic [BAUD_W-1:0] baud_q;
    logic [NFLAG-1:0]  sw_set, sw_clr, hw_set, flags, ie_mask;
    logic              rx_rise, tx_rise;
    logic [STAT_W-1:0] status;

    // write decode
    always_comb begin
        widx    = bus_addr[4:2];
        we_data = bus_wr && (widx == W_DATA);
        we_ctrl = bus_wr && (widx == W_CTRL);
        we_baud = bus_wr && (widx == W_BAUD);
        we_cmd  = bus_wr && (widx == W_CMD);
    end

    // control and baud storage
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
            baud_q <= '0;
        end else begin
            if (we_ctrl) ctrl_q <= bus_wdata[CTRL_W-1:0];
            if (we_baud) baud_q <= bus_wdata[BAUD_W-1:0];
        end
    end

    // command word to per-flag requests, and enable bits to flag order
    always_comb begin
        sw_set = '0;
        sw_clr = '0;
        ie_mask = '0;
        for (int s = 0; s < 5; s++) begin
            sw_clr[rx_flag_at(s)]  = we_cmd && bus_wdata[s];
            sw_set[rx_flag_at(s)]  = we_cmd && bus_wdata[s + C_SETOFS];
            ie_mask[rx_flag_at(s)] = ctrl_q[s];
        end
        sw_clr[F_TRDY]  = we_cmd && bus_wdata[C_TRDYC];
        sw_set[F_TRDY]  = we_cmd && bus_wdata[C_TRDYS];
        ie_mask[F_TRDY] = ctrl_q[5];
    end

    // hardware set requests
    always_comb begin
        hw_set         = '0;
        hw_set[F_RRDY] = rx_rise;
        hw_set[F_TRDY] = tx_rise;
        hw_set[F_OE]   = ev_overrun;
        hw_set[F_BRK]  = ev_break;
        hw_set[F_FE]   = ev_frame;
        hw_set[F_PE]   = ev_parity;
    end

    uart_flag_bank #(.NF(NFLAG)) u_flags (
        .clk    (clk),
        .rst_n  (rst_n),
        .sw_set (sw_set),
        .sw_clr (sw_clr),
        .hw_set (hw_set),
        .flags  (flags)
    );

    uart_rdy_gen #(.CNT_W(CNT_W), .DLY_W(DLY_W), .THR_W(THR_W)) u_rdy (
        .clk      (clk),
        .rst_n    (rst_n),
        .rx_count (rx_count),
        .tx_count (tx_count),
        .bit_tick (bit_tick),
        .rx_delay (ctrl_q[K_DLY_LO +: DLY_W]),
        .tx_thr   (ctrl_q[K_THR_LO +: THR_W]),
        .rx_rise  (rx_rise),
        .tx_rise  (tx_rise)
    );

    // one-cycle FIFO requests, registered off the write
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_pop   <= 1'b0;
            rx_flush <= 1'b0;
            tx_flush <= 1'b0;
            tx_push  <= 1'b0;
            tx_byte  <= '0;
        end else begin
            rx_pop   <= we_cmd && bus_wdata[C_POP];
            rx_flush <= we_cmd && bus_wdata[C_RXCLR];
            tx_flush <= we_cmd && bus_wdata[C_TXCLR];
            tx_push  <= we_data;
            if (we_data) tx_byte <= bus_wdata[7:0];
        end
    end

    // status word assembly and read mux
    always_comb begin
        status = '0;
        status[NFLAG-1:0]         = flags;
        status[RXC_LO +: CNT_W]   = rx_count;
        status[TXC_LO +: CNT_W]   = tx_count;
        case (widx)
            W_DATA:  bus_rdata = {24'b0, rx_head};
            W_CTRL:  bus_rdata = 32'(ctrl_q);
            W_BAUD:  bus_rdata = 32'(baud_q);
            W_STAT:  bus_rdata = 32'(status);
            W_ID:    bus_rdata = ID_WORD;
            default: bus_rdata = '0;
        endcase
    end

    assign irq       = |(flags & ie_mask);
    assign frame_cfg = ctrl_q[K_FRM_LO +: 8];
    assign baud_cfg  = baud_q;
endmodule

// File: rtl/uart_hostregs_chk.sv
// Module: uart_hostregs_chk
// Assertion checker bound to uart_hostregs. It watches the bus, the
// event inputs, the flag register and the pulse outputs.
module uart_hostregs_chk
    import uart_hreg_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             bus_wr,
    input logic [4:0]       bus_addr,
    input logic [31:0]      bus_wdata,
    input logic             ev_overrun,
    input logic [NFLAG-1:0] flags,
    input logic             irq,
    input logic             rx_pop,
    input logic             tx_push
);
    logic cmd_wr;
    assign cmd_wr = bus_wr && (bus_addr[4:2] == W_CMD);

    // R5: a set bit wins over a clear bit in the same write
    assert_set_wins_R5: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_wr && bus_wdata[6] && bus_wdata[1] |=> flags[F_OE]);

    // R6: an overrun pulse sets the flag at the next edge
    assert_hw_sets_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ev_overrun |=> flags[F_OE]);

    // R6: the overrun flag holds unless a clear arrives
    assert_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        flags[F_OE] && !(cmd_wr && bus_wdata[1]) |=> flags[F_OE]);

    // R4: a lone clear drops the flag
    assert_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_wr && bus_wdata[1] && !bus_wdata[6] && !ev_overrun |=> !flags[F_OE]);

    // R7: the software set of transmit-ready takes effect
    assert_trdy_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_wr && bus_wdata[C_TRDYS] |=> flags[F_TRDY]);

    // R9: no interrupt without a flag
    assert_irq_needs_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
        flags == '0 |-> !irq);

    // R10: a pop request becomes a single-cycle pulse
    assert_pop_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_wr && bus_wdata[C_POP] |=> rx_pop);
    assert_pop_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
        rx_pop && !$past(cmd_wr && bus_wdata[C_POP]) |-> 1'b0);

    // R11: a data write becomes a push in the next cycle
    assert_push_R11: assert property (@(posedge clk) disable iff (!rst_n)
        bus_wr && bus_addr[4:2] == W_DATA |=> tx_push);
endmodule

bind uart_hostregs uart_hostregs_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_wr     (bus_wr),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .ev_overrun (ev_overrun),
    .flags      (flags),
    .irq        (irq),
    .rx_pop     (rx_pop),
    .tx_push    (tx_push)
);

// File: tb/uart_hostregs_test.sv
`timescale 1ns/1ps
// Bench for uart_hostregs: a table of command/event vectors, then
// directed tests of reset, ready generation, irq, pulses and readback.
module uart_hostregs_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [7:0]  rx_head = 8'h3C;
    logic [4:0]  rx_count = '0;
    logic [4:0]  tx_count = 5'd8;
    logic        bit_tick = 1'b0;
    logic        ev_overrun = 1'b0, ev_break = 1'b0, ev_frame = 1'b0, ev_parity = 1'b0;
    logic        irq, rx_pop, rx_flush, tx_flush, tx_push;
    logic [7:0]  tx_byte, frame_cfg;
    logic [15:0] baud_cfg;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    uart_hostregs uut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .rx_head(rx_head),
        .rx_count(rx_count), .tx_count(tx_count), .bit_tick(bit_tick),
        .ev_overrun(ev_overrun), .ev_break(ev_break), .ev_frame(ev_frame),
        .ev_parity(ev_parity), .irq(irq), .rx_pop(rx_pop), .rx_flush(rx_flush),
        .tx_flush(tx_flush), .tx_push(tx_push), .tx_byte(tx_byte),
        .frame_cfg(frame_cfg), .baud_cfg(baud_cfg)
    );

    // {command[14:0], events {pe,fe,brk,oe}, expected status[5:0]}
    localparam logic [24:0] VEC [0:11] = '{
        {15'h0040, 4'h0, 6'h04},   // R4 set overrun
        {15'h0220, 4'h0, 6'h25},   // R4 set rrdy and parity
        {15'h0002, 4'h0, 6'h21},   // R4 clear overrun only
        {15'h4000, 4'h0, 6'h23},   // R4 set trdy
        {15'h2011, 4'h0, 6'h00},   // R4 clear rrdy, parity, trdy
        {15'h0084, 4'h0, 6'h08},   // R5 set and clear break together
        {15'h0000, 4'h4, 6'h18},   // R6 framing event
        {15'h0008, 4'h4, 6'h18},   // R5 event beats clear
        {15'h0008, 4'h0, 6'h08},   // R4 clear framing
        {15'h0004, 4'h9, 6'h24},   // R6 overrun+parity events, clear break
        {15'h0112, 4'h0, 6'h10},   // R4 set framing, clear overrun+parity
        {15'h0008, 4'h0, 6'h00}    // R4 clear framing
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    // one write; returns at the falling edge after the capturing edge
    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0; bus_wdata = '0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [31:0] d);
        bus_addr = a;
        #0.5;
        d = bus_rdata;
    endtask

    task automatic tick();
        @(negedge clk);
        bit_tick = 1'b1;
        @(negedge clk);
        bit_tick = 1'b0;
    endtask

    initial begin
        logic [31:0] r;
        // R1 reset state
        repeat (3) @(negedge clk);
        rd(5'd16, r);
        check("R1 status", r, 32'h0000_4000);
        rd(5'd4, r);
        check("R1 control", r, 32'h0);
        check("R1 outputs", {27'b0, irq, rx_pop, rx_flush, tx_flush, tx_push}, 32'h0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        rd(5'd16, r);
        check("R1 flags after reset", r, 32'h0000_4000);

        // table walk: R4 R5 R6
        for (int i = 0; i < 12; i++) begin
            @(negedge clk);
            bus_wr = 1'b1; bus_addr = 5'd12;
            bus_wdata = {17'b0, VEC[i][24:10]};
            ev_overrun = VEC[i][6]; ev_break = VEC[i][7];
            ev_frame = VEC[i][8];   ev_parity = VEC[i][9];
            @(negedge clk);
            bus_wr = 1'b0; bus_wdata = '0;
            {ev_overrun, ev_break, ev_frame, ev_parity} = 4'b0;
            rd(5'd16, r);
            check($sformatf("R4/R5/R6 vector %0d", i), {26'b0, r[5:0]}, {26'b0, VEC[i][5:0]});
        end

        // R3 layout, and R8 with zero delay
        @(negedge clk);
        rx_count = 5'd5;
        @(negedge clk);
        rd(5'd16, r);
        check("R3 status layout / R8 zero delay", r, 32'h0000_4141);
        rd(5'd12, r);
        check("R3 command word reads 0", r, 32'h0);
        rx_count = 5'd0;
        wr(5'd12, 32'h1);

        // R8 delay of three bit times
        wr(5'd4, 32'd3 << 14);
        @(negedge clk);
        rx_count = 5'd2;
        tick(); tick();
        rd(5'd16, r);
        check("R8 not ready after 2 ticks", {31'b0, r[0]}, 32'h0);
        tick();
        rd(5'd16, r);
        check("R8 not ready on the counting edge", {31'b0, r[0]}, 32'h0);
        @(negedge clk);
        rd(5'd16, r);
        check("R8 ready one edge later", {31'b0, r[0]}, 32'h1);
        wr(5'd12, 32'h1);
        repeat (2) @(negedge clk);
        rd(5'd16, r);
        check("R8 no re-set while condition holds", {31'b0, r[0]}, 32'h0);
        rx_count = 5'd0;
        @(negedge clk);
        rx_count = 5'd2;
        tick(); tick();
        @(negedge clk);
        rd(5'd16, r);
        check("R8 counter restarted after empty", {31'b0, r[0]}, 32'h0);
        tick();
        @(negedge clk);
        rd(5'd16, r);
        check("R8 ready after restart", {31'b0, r[0]}, 32'h1);
        wr(5'd12, 32'h1);
        rx_count = 5'd0;

        // R7 threshold of 4
        wr(5'd4, 32'd4 << 22);
        @(negedge clk);
        tx_count = 5'd4;
        @(negedge clk);
        rd(5'd16, r);
        check("R7 trdy at fill == threshold", {31'b0, r[1]}, 32'h1);
        tx_count = 5'd3;
        wr(5'd12, 32'h2000);
        @(negedge clk);
        rd(5'd16, r);
        check("R7 cleared trdy not set again", {31'b0, r[1]}, 32'h0);
        tx_count = 5'd5;
        @(negedge clk);
        tx_count = 5'd4;
        @(negedge clk);
        rd(5'd16, r);
        check("R7 trdy on new crossing", {31'b0, r[1]}, 32'h1);
        tx_count = 5'd8;
        wr(5'd12, 32'h2000);

        // R9 enable mapping
        wr(5'd4, 32'h2);
        check("R9 enabled but no flag", {31'b0, irq}, 32'h0);
        wr(5'd12, 32'h40);
        check("R9 overrun enabled", {31'b0, irq}, 32'h1);
        wr(5'd4, 32'h4);
        check("R9 only break enabled", {31'b0, irq}, 32'h0);
        wr(5'd12, 32'h80);
        check("R9 break enabled and set", {31'b0, irq}, 32'h1);
        wr(5'd12, 32'h6);
        check("R9 flags cleared", {31'b0, irq}, 32'h0);
        wr(5'd4, 32'h0);

        // R10 pulses
        wr(5'd12, 32'h1C00);
        check("R10 pulses high", {29'b0, rx_pop, rx_flush, tx_flush}, 32'h7);
        @(negedge clk);
        check("R10 pulses one cycle", {29'b0, rx_pop, rx_flush, tx_flush}, 32'h0);

        // R11 data, id
        wr(5'd0, 32'h1A5);
        check("R11 push and byte", {23'b0, tx_push, tx_byte}, {23'b0, 1'b1, 8'hA5});
        @(negedge clk);
        check("R11 push one cycle", {31'b0, tx_push}, 32'h0);
        rd(5'd0, r);
        check("R11 data read", r, 32'h3C);
        rd(5'd20, r);
        check("R11 id word", r, 32'h5A17_0001);

        // R2 readback
        wr(5'd8, 32'hABCD_1234);
        rd(5'd8, r);
        check("R2 baud readback", r, 32'h1234);
        check("R2 baud_cfg", {16'b0, baud_cfg}, 32'h1234);
        wr(5'd4, 32'hFFFF_FFFF);
        rd(5'd4, r);
        check("R2 control readback", r, 32'h03FF_FFFF);
        check("R2 frame_cfg", {24'b0, frame_cfg}, 32'hFF);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    // watchdog
    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule